// File: doc/BRIEF.md
# NAND Page Read Sequencer

This block runs the read of one page of a raw NAND flash device. It drives the command and address latch strobes, waits on the device's ready/busy line, and then pulls the requested number of bytes off the data bus with a read strobe. The bytes leave the block on a valid/ready byte stream. A caller supplies a 24-bit page address, a flag that picks the spare (out-of-band) area or the main area, a byte count, and a one-cycle start pulse. The block answers with the byte stream and a one-cycle done pulse.

Parameters set the device geometry. These are large pages or 512-byte small pages, 2 or 3 row-address bytes, and an 8- or 16-bit data bus. A spare read on a large-page device starts its column at the page size. A spare read on a small-page device uses the dedicated spare-read opcode, sends one column byte and no confirm opcode, and waits for ready both before the command and after the last byte. Every ready wait has two phases. The first phase watches for busy for at most `BUSY_LIMIT` cycles. The second phase waits with no bound for ready to come back.

Stream rules: `out_data` is meaningful while `out_valid` is high. A byte moves on a cycle where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the byte is held unchanged. No new bus read is issued until every byte of the previous bus word has been accepted, so back-pressure stops the device reads.

Top module: `nand_page_reader`

## Requirements
- R1: On a large-page device, the order is: command byte 0x00 (with `nf_cle`), two column bytes low byte first, the row bytes low byte first (with `nf_ale`), command 0x30, a ready wait, and then the data reads.
- R2: A large-page spare read uses column address `PAGE_BYTES`.
- R3: A main-area read always uses column address 0. On a small-page device, a main read sends command 0x00, one column byte 0 and the row bytes, with no confirm command.
- R4: Exactly `ROW_BYTES` row bytes (2 or 3) are sent, taken from page address bits 7:0, then 15:8, then 23:16.
- R5: A small-page spare read sends command 0x50, one column byte 0x00 and the row bytes, with no confirm. It runs a full ready wait before the command and another one after the last byte.
- R6: A ready wait first waits up to `BUSY_LIMIT` cycles for `nf_rb` to go low, then waits with no bound for `nf_rb` high. No strobe is driven while `nf_rb` is low.
- R7: In any cycle at most one of `nf_cle`, `nf_ale`, `nf_re` is high, and each strobe is high for one cycle per bus transfer. `nf_ce` is high from the cycle after start until the done cycle, and in no other cycle.
- R8: With a 16-bit bus, one read strobe yields two bytes, the low byte (bits 7:0) first. For an odd count, the high byte of the last word is dropped, so the number of read strobes is the count divided by two, rounded up.
- R9: Bytes leave in device order. While `out_valid` is high and `out_ready` is low, `out_data` holds steady.
- R10: A start pulse that arrives before done is ignored.
- R11: `done` is high for exactly one cycle. On a large-page device it comes in the cycle after the last byte is accepted. A byte count of 0 gives no read strobes.
- R12: After reset, `nf_ce`, every strobe, `out_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to read a page |
| page_addr | input | 24 | Page (row) address |
| spare_sel | input | 1 | 1 = spare area, 0 = main area |
| byte_count | input | CNT_W | Number of bytes to deliver |
| nf_ce | output | 1 | Chip enable, active high |
| nf_cle | output | 1 | Command latch strobe |
| nf_ale | output | 1 | Address latch strobe |
| nf_we | output | 1 | Write strobe, high with either latch strobe |
| nf_re | output | 1 | Read strobe; `nf_din` is sampled on this cycle's clock edge |
| nf_dout | output | BUS_W | Command/address byte on bits 7:0 |
| nf_din | input | BUS_W | Data from the device |
| nf_rb | input | 1 | Ready (1) / busy (0) from the device |
| out_valid | output | 1 | Stream byte valid |
| out_ready | input | 1 | Stream sink ready |
| out_data | output | 8 | Stream byte |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong sequencer state shows up in the captured command/address log right away. It appears as a missing confirm byte, a wrong column byte or an extra row byte, or as a strobe while busy or outside chip enable, caught in the cycle it happens. A faulty unpacking or back-pressure path shows as a byte that differs from the device pattern at the exact stream position, or as a data change during a stall. A faulty wait shows as a transaction that finishes sooner than the forced busy time, or as a read strobe while the device model is busy.

// File: rtl/nprd_pkg.sv
package nprd_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_PREWAIT, S_CMD, S_ADDR, S_CONF, S_WAIT, S_DATA, S_POSTWAIT, S_FIN
  } nprd_state_t;

  localparam logic [7:0] OP_READ    = 8'h00;
  localparam logic [7:0] OP_SPARE   = 8'h50;
  localparam logic [7:0] OP_CONFIRM = 8'h30;
endpackage

// File: rtl/nprd_rb_wait.sv
module nprd_rb_wait #(
  parameter int BUSY_LIMIT = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic rb,
  output logic fin
);
  localparam int CW = $clog2(BUSY_LIMIT + 1);
  typedef enum logic [1:0] {W_IDLE, W_FALL, W_RISE} wst_t;

  wst_t          ws;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws  <= W_IDLE;
      cnt <= '0;
    end else begin
      case (ws)
        W_IDLE: if (go) begin
          ws  <= W_FALL;
          cnt <= '0;
        end
        W_FALL: begin
          if (!rb || cnt == CW'(BUSY_LIMIT - 1)) ws <= W_RISE;
          else cnt <= cnt + 1'b1;
        end
        W_RISE: if (rb) ws <= W_IDLE;
        default: ws <= W_IDLE;
      endcase
    end
  end

  assign fin = (ws == W_RISE) && rb;
endmodule

// File: rtl/nprd_addr_gen.sv
module nprd_addr_gen #(
  parameter int SMALL_PAGE = 0,
  parameter int ROW_BYTES  = 3,
  parameter int PAGE_BYTES = 2048
) (
  input  logic [23:0] page,
  input  logic        spare,
  input  logic [2:0]  idx,
  output logic [7:0]  abyte
);
  localparam int          COL_BYTES = (SMALL_PAGE != 0) ? 1 : 2;
  localparam logic [15:0] SPARE_COL = 16'(PAGE_BYTES);

  logic [7:0]  lst [8];
  logic [15:0] col;

  generate
    if (SMALL_PAGE != 0) begin : g_small
      assign col = 16'h0000;
    end else begin : g_large
      assign col = spare ? SPARE_COL : 16'h0000;
    end
  endgenerate

  always_comb begin
    for (int k = 0; k < 8; k++) lst[k] = 8'h00;
    lst[0] = col[7:0];
    if (COL_BYTES == 2) lst[1] = col[15:8];
    for (int r = 0; r < ROW_BYTES; r++) lst[COL_BYTES + r] = page[8*r +: 8];
  end

  assign abyte = lst[idx];
endmodule

// File: rtl/nprd_unpack.sv
module nprd_unpack #(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [1:0]       load_lanes,
  input  logic [BUS_W-1:0] din,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic [1:0]       lanes
);
  logic [BUS_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      lanes  <= 2'd0;
    end else if (load) begin
      word_q <= din;
      lanes  <= load_lanes;
    end else if (out_valid && out_ready) begin
      word_q <= word_q >> 8;
      lanes  <= lanes - 2'd1;
    end
  end

  assign out_valid = (lanes != 2'd0);
  assign out_data  = word_q[7:0];
endmodule

// File: rtl/nand_page_reader.sv
module nand_page_reader
  import nprd_pkg::*;
#(
  parameter int BUS_W      = 8,
  parameter int ROW_BYTES  = 3,
  parameter int SMALL_PAGE = 0,
  parameter int PAGE_BYTES = 2048,
  parameter int CNT_W      = 13,
  parameter int BUSY_LIMIT = 10000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [23:0]      page_addr,
  input  logic             spare_sel,
  input  logic [CNT_W-1:0] byte_count,
  output logic             nf_ce,
  output logic             nf_cle,
  output logic             nf_ale,
  output logic             nf_we,
  output logic             nf_re,
  output logic [BUS_W-1:0] nf_dout,
  input  logic [BUS_W-1:0] nf_din,
  input  logic             nf_rb,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             done
);
  localparam int         N_ADDR = ((SMALL_PAGE != 0) ? 1 : 2) + ROW_BYTES;
  localparam logic [1:0] LANES  = 2'(BUS_W / 8);

  nprd_state_t      st;
  logic [2:0]       idx;
  logic [23:0]      page_q;
  logic             spare_q;
  logic [CNT_W-1:0] fetch_left;
  logic             wait_armed;
  logic             in_wait, wait_go, wait_fin;
  logic [7:0]       abyte, cbyte, bus_byte;
  logic [1:0]       lanes, ld_lanes;
  logic             pop, last_out, small_spare;

  assign small_spare = (SMALL_PAGE != 0) && spare_q;
  assign in_wait = (st == S_PREWAIT) || (st == S_WAIT) || (st == S_POSTWAIT);
  assign wait_go = in_wait && !wait_armed;

  nprd_rb_wait #(.BUSY_LIMIT(BUSY_LIMIT)) u_wait (
    .clk(clk), .rst_n(rst_n), .go(wait_go), .rb(nf_rb), .fin(wait_fin)
  );

  nprd_addr_gen #(.SMALL_PAGE(SMALL_PAGE), .ROW_BYTES(ROW_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_addr (
    .page(page_q), .spare(spare_q), .idx(idx), .abyte(abyte)
  );

  assign nf_re    = (st == S_DATA) && (lanes == 2'd0) && (fetch_left != '0);
  assign ld_lanes = (fetch_left >= CNT_W'(LANES)) ? LANES : fetch_left[1:0];

  nprd_unpack #(.BUS_W(BUS_W)) u_unpack (
    .clk(clk), .rst_n(rst_n), .load(nf_re), .load_lanes(ld_lanes), .din(nf_din),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data), .lanes(lanes)
  );

  assign pop      = out_valid && out_ready;
  assign last_out = (fetch_left == '0) && ((lanes == 2'd0) || (lanes == 2'd1 && pop));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      idx        <= 3'd0;
      page_q     <= '0;
      spare_q    <= 1'b0;
      fetch_left <= '0;
      wait_armed <= 1'b0;
    end else begin
      if (wait_fin)     wait_armed <= 1'b0;
      else if (wait_go) wait_armed <= 1'b1;
      if (nf_re) fetch_left <= fetch_left - CNT_W'(ld_lanes);
      case (st)
        S_IDLE: if (start) begin
          page_q     <= page_addr;
          spare_q    <= spare_sel;
          fetch_left <= byte_count;
          st <= ((SMALL_PAGE != 0) && spare_sel) ? S_PREWAIT : S_CMD;
        end
        S_PREWAIT: if (wait_fin) st <= S_CMD;
        S_CMD: begin
          idx <= 3'd0;
          st  <= S_ADDR;
        end
        S_ADDR: begin
          if (idx == 3'(N_ADDR - 1)) st <= (SMALL_PAGE != 0) ? S_WAIT : S_CONF;
          else idx <= idx + 3'd1;
        end
        S_CONF:     st <= S_WAIT;
        S_WAIT:     if (wait_fin) st <= S_DATA;
        S_DATA:     if (last_out) st <= small_spare ? S_POSTWAIT : S_FIN;
        S_POSTWAIT: if (wait_fin) st <= S_FIN;
        S_FIN:      st <= S_IDLE;
        default:    st <= S_IDLE;
      endcase
    end
  end

  assign cbyte    = small_spare ? OP_SPARE : OP_READ;
  assign nf_ce    = (st != S_IDLE);
  assign nf_cle   = (st == S_CMD) || (st == S_CONF);
  assign nf_ale   = (st == S_ADDR);
  assign nf_we    = nf_cle || nf_ale;
  assign done     = (st == S_FIN);
  assign bus_byte = (st == S_CMD) ? cbyte : (st == S_CONF) ? OP_CONFIRM : nf_ale ? abyte : 8'h00;
  assign nf_dout  = BUS_W'(bus_byte);
endmodule

// File: rtl/nprd_checker.sv
module nprd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       nf_ce,
  input logic       nf_cle,
  input logic       nf_ale,
  input logic       nf_re,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       done
);
  p_single_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nf_cle, nf_ale, nf_re}));

  p_strobe_in_ce_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (nf_cle || nf_ale || nf_re) |-> nf_ce);

  p_ce_drop_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nf_ce) |-> $past(done));

  p_ce_rise_on_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nf_ce) |-> $past(start));

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_with_ce_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (nf_ce && !out_valid));
endmodule

bind nand_page_reader nprd_checker u_nprd_checker (.*);

// File: tb/test_nand_page_reader.sv
module nand_dev_model #(
  parameter int BUS_W  = 8,
  parameter int TRIG_N = 4
) (
  input  logic             clk,
  input  logic             ce,
  input  logic             cle,
  input  logic             ale,
  input  logic             re,
  input  logic [BUS_W-1:0] wr_bus,
  input  logic [7:0]       seed,
  input  int               busy_len,
  output logic [BUS_W-1:0] rd_bus,
  output logic             rb
);
  logic [8:0] log_q [16];
  int log_n = 0, ptr = 0, reads = 0, viol = 0, busy_cnt = 0;

  function automatic logic [7:0] pat(int k);
    return 8'(k * 13) + seed;
  endfunction

  assign rb = (busy_cnt == 0);
  generate
    if (BUS_W == 16) begin : g16
      assign rd_bus = {pat(2 * ptr + 1), pat(2 * ptr)};
    end else begin : g8
      assign rd_bus = pat(ptr);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!ce) begin
      log_n <= 0; ptr <= 0; reads <= 0;
    end else begin
      if (cle || ale) begin
        if (log_n < 16) log_q[log_n[3:0]] <= {cle, wr_bus[7:0]};
        log_n <= log_n + 1;
      end
      if (re) begin ptr <= ptr + 1; reads <= reads + 1; end
    end
    if ((cle || ale) && ce && log_n == TRIG_N - 1) busy_cnt <= busy_len;
    else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
    if ((cle || ale || re) && (!ce || !rb)) viol <= viol + 1;
    if (int'(cle) + int'(ale) + int'(re) > 1) viol <= viol + 1;
  end
endmodule

module test_nand_page_reader;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 16;

  logic clk = 0, rst_n = 0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [1:0]  start_s = 0, spare_s = 0, rdy_s = 0;
  logic [23:0] page_s [2];
  logic [12:0] cnt_s [2];
  logic [7:0]  seed_s [2];
  int          busy_len [2];

  logic ce0, cle0, ale0, we0, re0, rb0, ov0, dn0; logic [15:0] do0, di0; logic [7:0] od0;
  logic ce1, cle1, ale1, we1, re1, rb1, ov1, dn1; logic [7:0] do1, di1; logic [7:0] od1;

  int checks = 0, fails = 0;

  nand_page_reader #(.BUS_W(16), .ROW_BYTES(3), .SMALL_PAGE(0), .PAGE_BYTES(2048),
                     .CNT_W(13), .BUSY_LIMIT(LIMIT)) i_nand_page_reader (
    .clk(clk), .rst_n(rst_n), .start(start_s[0]), .page_addr(page_s[0]), .spare_sel(spare_s[0]),
    .byte_count(cnt_s[0]), .nf_ce(ce0), .nf_cle(cle0), .nf_ale(ale0), .nf_we(we0), .nf_re(re0),
    .nf_dout(do0), .nf_din(di0), .nf_rb(rb0), .out_valid(ov0), .out_ready(rdy_s[0]),
    .out_data(od0), .done(dn0));

  nand_page_reader #(.BUS_W(8), .ROW_BYTES(2), .SMALL_PAGE(1), .PAGE_BYTES(512),
                     .CNT_W(13), .BUSY_LIMIT(LIMIT)) i_nand_page_reader_sp (
    .clk(clk), .rst_n(rst_n), .start(start_s[1]), .page_addr(page_s[1]), .spare_sel(spare_s[1]),
    .byte_count(cnt_s[1]), .nf_ce(ce1), .nf_cle(cle1), .nf_ale(ale1), .nf_we(we1), .nf_re(re1),
    .nf_dout(do1), .nf_din(di1), .nf_rb(rb1), .out_valid(ov1), .out_ready(rdy_s[1]),
    .out_data(od1), .done(dn1));

  nand_dev_model #(.BUS_W(16), .TRIG_N(7)) i_m0 (.clk(clk), .ce(ce0), .cle(cle0), .ale(ale0),
    .re(re0), .wr_bus(do0), .seed(seed_s[0]), .busy_len(busy_len[0]), .rd_bus(di0), .rb(rb0));
  nand_dev_model #(.BUS_W(8), .TRIG_N(4)) i_m1 (.clk(clk), .ce(ce1), .cle(cle1), .ale(ale1),
    .re(re1), .wr_bus(do1), .seed(seed_s[1]), .busy_len(busy_len[1]), .rd_bus(di1), .rb(rb1));

  function automatic logic [7:0] exp_b(int k, logic [7:0] sd);
    return 8'(k * 13) + sd;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  task automatic run(input int w, input logic [23:0] page, input bit spare, input int cnt,
                     input int busy, input logic [7:0] sd, input bit dup, input string tag);
    int nb = 0, bad = 0, bad_a = 0, bad_e = 0, dones = 0, done_cyc = -1, last_hs = -1;
    int cyc = 0, ce_cyc = 0, post_ce = 0, reads = 0, lg_n = 0, tail = 0, v0, exp_n, exp_reads;
    bit stall = 0, stall_bad = 0, v, d_n, c;
    logic [7:0] stall_d = 0, d;
    logic [8:0] lg [16];
    logic [8:0] ex [8];
    logic [15:0] col;
    v0 = (w == 0) ? i_m0.viol : i_m1.viol;
    busy_len[w] = busy; seed_s[w] = sd; page_s[w] = page; spare_s[w] = spare; cnt_s[w] = 13'(cnt);
    @(negedge clk); start_s[w] = 1'b1;
    @(negedge clk); start_s[w] = 1'b0;
    for (int i = 0; i < 20000 && tail < 6; i++) begin
      v = (w == 0) ? ov0 : ov1; d = (w == 0) ? od0 : od1;
      d_n = (w == 0) ? dn0 : dn1; c = (w == 0) ? ce0 : ce1;
      if (stall && (!v || d != stall_d)) stall_bad = 1;
      rdy_s[w] = ($urandom % 4) != 0;
      stall = v && !rdy_s[w]; stall_d = d;
      if (v && rdy_s[w]) begin
        if (d !== exp_b(nb, sd) && bad == 0) begin bad_a = int'(d); bad_e = int'(exp_b(nb, sd)); end
        if (d !== exp_b(nb, sd)) bad++;
        nb++; last_hs = cyc;
      end
      if (c) ce_cyc++;
      if (d_n) begin
        dones++; done_cyc = cyc;
        if (dones == 1) begin
          if (w == 0) begin
            lg_n = i_m0.log_n; reads = i_m0.reads;
            for (int k = 0; k < 16; k++) lg[k] = i_m0.log_q[k];
          end else begin
            lg_n = i_m1.log_n; reads = i_m1.reads;
            for (int k = 0; k < 16; k++) lg[k] = i_m1.log_q[k];
          end
        end
      end else if (dones > 0 && c) post_ce++;
      start_s[w] = dup && (cyc == 3);
      if (dones > 0) tail++;
      cyc++;
      @(negedge clk);
    end
    rdy_s[w] = 1'b0; start_s[w] = 1'b0;
    // expected command/address log
    col = (w == 0 && spare) ? 16'd2048 : 16'd0;
    if (w == 0) begin
      ex[0] = 9'h100; ex[1] = {1'b0, col[7:0]}; ex[2] = {1'b0, col[15:8]};
      ex[3] = {1'b0, page[7:0]}; ex[4] = {1'b0, page[15:8]}; ex[5] = {1'b0, page[23:16]};
      ex[6] = 9'h130; exp_n = 7; exp_reads = (cnt + 1) / 2;
    end else begin
      ex[0] = spare ? 9'h150 : 9'h100; ex[1] = 9'h000;
      ex[2] = {1'b0, page[7:0]}; ex[3] = {1'b0, page[15:8]}; exp_n = 4; exp_reads = cnt;
    end
    chk(lg_n == exp_n, $sformatf("%s address/command count", tag), lg_n, exp_n);
    for (int k = 0; k < exp_n && k < 8; k++)
      chk(lg[k] == ex[k], $sformatf("%s log entry %0d", tag, k), int'(lg[k]), int'(ex[k]));
    chk(bad == 0, $sformatf("R9 %s data byte", tag), bad_a, bad_e);
    chk(nb == cnt, "R9 byte count delivered", nb, cnt);
    chk(reads == exp_reads, "R8 read strobe count", reads, exp_reads);
    chk(dones == 1, "R11 done pulse count", dones, 1);
    chk(!stall_bad, "R9 data held during stall", int'(stall_bad), 0);
    chk(post_ce == 0, "R7 ce released after done", post_ce, 0);
    chk(((w == 0) ? i_m0.viol : i_m1.viol) == v0, "R6 R7 strobe outside ce or while busy",
        ((w == 0) ? i_m0.viol : i_m1.viol) - v0, 0);
    if (w == 0 && cnt > 0) chk(done_cyc == last_hs + 1, "R11 done timing", done_cyc, last_hs + 1);
    chk(ce_cyc >= busy, "R6 waits out the busy time", ce_cyc, busy);
  endtask

  initial begin
    page_s[0] = 0; page_s[1] = 0; cnt_s[0] = 0; cnt_s[1] = 0; seed_s[0] = 0; seed_s[1] = 0;
    busy_len[0] = 0; busy_len[1] = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!ce0 && !cle0 && !ale0 && !re0 && !ov0 && !dn0, "R12 reset state wide", int'(ce0), 0);
    chk(!ce1 && !cle1 && !ale1 && !re1 && !ov1 && !dn1, "R12 reset state small", int'(ce1), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ce0 && !ce1 && !dn0 && !dn1, "R12 idle after reset", int'(ce0 | ce1), 0);
    run(0, 24'h123456, 0, 8,  5,  8'h11, 0, "R1 R3 R4 main");
    run(0, 24'hA5C30F, 1, 64, 5,  8'h22, 0, "R2 spare column");
    run(0, 24'h000102, 0, 7,  3,  8'h33, 0, "R8 odd count");
    run(0, 24'h0F0F0F, 0, 6,  0,  8'h44, 0, "R6 timeout phase");
    run(0, 24'h777777, 0, 6,  40, 8'h55, 0, "R6 long busy");
    run(0, 24'h010203, 0, 0,  4,  8'h66, 0, "R11 zero count");
    run(0, 24'h3C3C3C, 0, 10, 8,  8'h77, 1, "R10 second start");
    run(1, 24'h00BEEF, 1, 16, 3,  8'h88, 0, "R5 small spare");
    run(1, 24'h004321, 0, 12, 6,  8'h99, 0, "R3 small main");
    for (int n = 0; n < 24; n++) begin
      int w = int'($urandom % 2);
      run(w, 24'($urandom), 1'($urandom), int'($urandom % 41), int'($urandom % 31),
          8'($urandom), 1'($urandom % 4 == 0), (w == 0) ? "R1 R4 random" : "R4 R5 random");
    end
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    summary();
    $finish;
  end
endmodule